// File: doc/BRIEF.md
# Serial EEPROM Command Interface

This block is the slave side of a three-wire serial link that is framed by a chip select. A host shifts in fixed 32-bit instruction frames. The block decodes each frame into one of several actions: a word read, a word write, a pulse that enables programming, a pulse that disables programming, a pulse that enters power-down or a pulse that leaves it. The storage array sits behind a plain synchronous port. A read strobe returns data in the following system-clock cycle, and a write strobe commits one word.

The serial pins are asynchronous to the system clock, so the block synchronises and edge-detects them on that clock. A read streams data out MSB first. Once the addressed word has been sent, the block keeps going with the next word and wraps inside the region that was addressed: the 256 general-purpose 16-bit words, or the four 8-bit converter registers. After a write, the data output reports ready/busy for a self-timed programming period. That period is measured in system clocks.

Top module: `nvm_serial_port`

## Requirements
- R1: After reset the data output is not driven (`sdo_oe_o` low), and no memory strobe or command pulse is issued.
- R2: Input bits are sampled on rising serial-clock edges while chip select is high. A frame is sent in this order: the 7-bit op-code, address bit 8, address bits 7..0, then 16 data bits, MSB first. That makes 32 bits.
- R3: Op-code 1010010 (write) issues a single `mem_wr_o` strobe after the 32nd rising edge. The strobe carries the address and the 16 data bits. In the converter region the written word is `{8'h00, D7..D0}`.
- R4: Each of the op-codes 1010001 (programming on), 1010000 (programming off), 1010110 (power-down on) and 1010011 (power-down off) issues one single-cycle pulse on its own output after the 32nd rising edge. Its address and data bits have no effect. Any other op-code except read and write produces nothing.
- R5: Op-code 1010100 (read) drives the data output from the falling edge that follows the 16th rising edge. The serial clock idles high, so this is the 17th falling edge of the frame. From that edge the block sends D15 first, and it keeps the output driven until chip select drops.
- R6: A read that continues past 16 bits moves on to the next word. In the general region (address bit 8 = 0) the next address is the current one plus 1 modulo 256, so 0x0FF is followed by 0x000.
- R7: Addresses with bit 8 set select converter register A1..A0, at 0x100 to 0x103. Bits 7..2 are not decoded. A read from this region returns the stored byte in bits 7..0, with zero in bits 15..8. A continued read wraps from 0x103 to 0x100.
- R8: After a write, the data output is driven low for `BUSY_CYCLES` system clocks and then driven high. This happens whether or not chip select is still high.
- R9: The ready/busy indication ends at one of two points. The first is a falling edge of chip select once the busy period is over. The second is the first rising serial-clock edge of the next accepted frame.
- R10: A frame whose chip select rises while the busy period is running is ignored completely.
- R11: If chip select drops before the 32nd rising edge, the frame is abandoned and nothing is executed. The next frame is decoded from its first bit.
- R12: The data output is not driven at any other time, including during the header and data bits of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sclk_i | input | 1 | Serial clock, idles high, asynchronous |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for the data-out pin; low means high impedance |
| mem_addr_o | output | 9 | Array address for read or write strobe |
| mem_rd_o | output | 1 | Read strobe; data expected on `mem_rdata_i` next cycle |
| mem_rdata_i | input | 16 | Read data from the array |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 16 | Write data |
| wren_pulse_o | output | 1 | Programming-enable command pulse |
| wrds_pulse_o | output | 1 | Programming-disable command pulse |
| pden_pulse_o | output | 1 | Power-down-enable command pulse |
| pdds_pulse_o | output | 1 | Power-down-disable command pulse |

## Verification
The properties assume three things about the environment. Every serial-clock phase lasts several system clocks longer than the synchroniser depth. Chip select changes only while the serial clock is high. The array answers a read strobe in the very next cycle. The stimulus holds each serial-clock phase for six system clocks and moves chip select only with the clock parked high. The bench memory model responds to every strobe on the following cycle. Under these conditions, the prefetched word is in place before each launch edge, and chip-select edges never coincide with data edges.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
    localparam int OP_W      = 7;
    localparam int ADDR_W    = 9;
    localparam int GEN_AW    = 8;
    localparam int DAC_SEL_W = 2;
    localparam int DATA_W    = 16;
    localparam int DAC_DW    = 8;
    localparam int HDR_BITS  = OP_W + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_BITS + 1);
    localparam int OCNT_W    = $clog2(DATA_W);

    localparam logic [OP_W-1:0] OPC_READ  = 7'b1010100;
    localparam logic [OP_W-1:0] OPC_WRITE = 7'b1010010;
    localparam logic [OP_W-1:0] OPC_WREN  = 7'b1010001;
    localparam logic [OP_W-1:0] OPC_WRDS  = 7'b1010000;
    localparam logic [OP_W-1:0] OPC_PDEN  = 7'b1010110;
    localparam logic [OP_W-1:0] OPC_PDDS  = 7'b1010011;

    // Converter region keeps only the register select bits.
    function automatic logic [ADDR_W-1:0] nsp_fold_addr(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1])
            return {1'b1, {(GEN_AW-DAC_SEL_W){1'b0}}, a[DAC_SEL_W-1:0]};
        return a;
    endfunction

    // Next word for a continued read; wraps inside the addressed region.
    function automatic logic [ADDR_W-1:0] nsp_next_addr(input logic [ADDR_W-1:0] a);
        logic [DAC_SEL_W-1:0] sel_n;
        logic [GEN_AW-1:0]    gen_n;
        sel_n = a[DAC_SEL_W-1:0] + 1'b1;
        gen_n = a[GEN_AW-1:0] + 1'b1;
        if (a[ADDR_W-1])
            return {1'b1, {(GEN_AW-DAC_SEL_W){1'b0}}, sel_n};
        return {1'b0, gen_n};
    endfunction
endpackage

// File: rtl/nsp_sync.sv
module nsp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[STAGES-1:0], async_i[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= pipe_d;
        end

        assign level_o[i] = pipe_q[STAGES-1];
        assign rise_o[i]  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
        assign fall_o[i]  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end
endmodule

// File: rtl/nsp_busy_timer.sv
module nsp_busy_timer #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CW'(CYCLES - 1);
        end else if (s_q.busy) begin
            if (s_q.cnt == '0) s_d.busy = 1'b0;
            else               s_d.cnt  = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !s_q.busy);                                     // R10
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0 && !start_i) |=> s_q.busy);      // R8
endmodule

// File: rtl/nvm_serial_port.sv
module nvm_serial_port
    import nsp_pkg::*;
#(
    parameter int BUSY_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_i,
    input  logic               sclk_i,
    input  logic               sdi_i,
    output logic               sdo_o,
    output logic               sdo_oe_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic               mem_rd_o,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    output logic               mem_wr_o,
    output logic [DATA_W-1:0]  mem_wdata_o,
    output logic               wren_pulse_o,
    output logic               wrds_pulse_o,
    output logic               pden_pulse_o,
    output logic               pdds_pulse_o
);
    localparam int NPULSE = 4;
    localparam int PAD_W  = DATA_W - DAC_DW;

    typedef struct packed {
        logic                in_frame;
        logic [CNT_W-1:0]    bit_cnt;
        logic [HDR_BITS-1:0] shreg;
        logic [OP_W-1:0]     op;
        logic [ADDR_W-1:0]   addr;
        logic                rd_act;
        logic                rd_drv;
        logic [OCNT_W-1:0]   ocnt;
        logic [DATA_W-1:0]   osh;
        logic [DATA_W-1:0]   nxt;
        logic                cap;
        logic                cap_dac;
        logic                status;
        logic                sdo;
        logic                sdo_oe;
        logic                mem_rd;
        logic                mem_wr;
        logic [ADDR_W-1:0]   mem_addr;
        logic [DATA_W-1:0]   mem_wdata;
        logic [NPULSE-1:0]   pulse;
    } port_t;

    port_t s_d, s_q;

    logic [2:0] pin_lvl, pin_rise, pin_fall;
    logic       cs_rise, cs_fall, sck_rise, sck_fall, sdi_lvl;
    logic       busy, wr_go;
    logic       unused_pins;

    nsp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi_i, sclk_i, cs_i}),
        .level_o (pin_lvl),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    assign cs_rise     = pin_rise[0];
    assign cs_fall     = pin_fall[0];
    assign sck_rise    = pin_rise[1];
    assign sck_fall    = pin_fall[1];
    assign sdi_lvl     = pin_lvl[2];
    assign unused_pins = ^{pin_lvl[1:0], pin_rise[2], pin_fall[2]};

    nsp_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wr_go),
        .busy_o  (busy)
    );

    logic [HDR_BITS-1:0] sh_n;
    logic [CNT_W-1:0]    cnt_n;
    logic [ADDR_W-1:0]   hdr_addr, adv_addr;

    always_comb begin
        s_d        = s_q;
        s_d.mem_rd = 1'b0;
        s_d.mem_wr = 1'b0;
        s_d.pulse  = '0;
        s_d.cap    = s_q.mem_rd;
        wr_go      = 1'b0;
        sh_n       = {s_q.shreg[HDR_BITS-2:0], sdi_lvl};
        cnt_n      = s_q.bit_cnt + 1'b1;
        hdr_addr   = nsp_fold_addr(sh_n[ADDR_W-1:0]);
        adv_addr   = nsp_next_addr(s_q.addr);

        // Array word arrives the cycle after the strobe.
        if (s_q.cap)
            s_d.nxt = s_q.cap_dac ? {{PAD_W{1'b0}}, mem_rdata_i[DAC_DW-1:0]} : mem_rdata_i;

        if (cs_fall) begin
            s_d.in_frame = 1'b0;
            s_d.bit_cnt  = '0;
            s_d.rd_act   = 1'b0;
            s_d.rd_drv   = 1'b0;
            if (!busy) s_d.status = 1'b0;
        end else if (cs_rise) begin
            if (!busy) begin
                s_d.in_frame = 1'b1;
                s_d.bit_cnt  = '0;
                s_d.rd_act   = 1'b0;
                s_d.rd_drv   = 1'b0;
            end
        end else if (s_q.in_frame && !s_q.rd_act && sck_rise) begin
            s_d.status  = 1'b0;
            s_d.shreg   = sh_n;
            s_d.bit_cnt = cnt_n;
            if (cnt_n == CNT_W'(HDR_BITS)) begin
                s_d.op   = sh_n[HDR_BITS-1:ADDR_W];
                s_d.addr = hdr_addr;
                if (sh_n[HDR_BITS-1:ADDR_W] == OPC_READ) begin
                    s_d.rd_act   = 1'b1;
                    s_d.ocnt     = '0;
                    s_d.mem_rd   = 1'b1;
                    s_d.mem_addr = hdr_addr;
                    s_d.cap_dac  = hdr_addr[ADDR_W-1];
                end
            end
            if (cnt_n == CNT_W'(FRAME_BITS)) begin
                s_d.in_frame = 1'b0;
                unique case (s_q.op)
                    OPC_WRITE: begin
                        s_d.mem_wr    = 1'b1;
                        s_d.mem_addr  = s_q.addr;
                        s_d.mem_wdata = s_q.addr[ADDR_W-1] ?
                                        {{PAD_W{1'b0}}, sh_n[DAC_DW-1:0]} : sh_n;
                        s_d.status    = 1'b1;
                        wr_go         = 1'b1;
                    end
                    OPC_WREN: s_d.pulse[0] = 1'b1;
                    OPC_WRDS: s_d.pulse[1] = 1'b1;
                    OPC_PDEN: s_d.pulse[2] = 1'b1;
                    OPC_PDDS: s_d.pulse[3] = 1'b1;
                    default: ;
                endcase
            end
        end else if (s_q.rd_act && sck_fall) begin
            s_d.rd_drv = 1'b1;
            s_d.ocnt   = s_q.ocnt + 1'b1;
            if (s_q.ocnt == '0) begin
                s_d.sdo      = s_q.nxt[DATA_W-1];
                s_d.osh      = {s_q.nxt[DATA_W-2:0], 1'b0};
                s_d.addr     = adv_addr;
                s_d.mem_rd   = 1'b1;
                s_d.mem_addr = adv_addr;
                s_d.cap_dac  = adv_addr[ADDR_W-1];
            end else begin
                s_d.sdo = s_q.osh[DATA_W-1];
                s_d.osh = {s_q.osh[DATA_W-2:0], 1'b0};
            end
        end

        if (s_d.rd_drv) begin
            s_d.sdo_oe = 1'b1;
        end else if (s_d.status) begin
            s_d.sdo_oe = 1'b1;
            s_d.sdo    = ~(busy | wr_go);
        end else begin
            s_d.sdo_oe = 1'b0;
            s_d.sdo    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sdo_o        = s_q.sdo;
    assign sdo_oe_o     = s_q.sdo_oe;
    assign mem_addr_o   = s_q.mem_addr;
    assign mem_rd_o     = s_q.mem_rd;
    assign mem_wr_o     = s_q.mem_wr;
    assign mem_wdata_o  = s_q.mem_wdata;
    assign wren_pulse_o = s_q.pulse[0];
    assign wrds_pulse_o = s_q.pulse[1];
    assign pden_pulse_o = s_q.pulse[2];
    assign pdds_pulse_o = s_q.pulse[3];

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr_o, wren_pulse_o, wrds_pulse_o, pden_pulse_o, pdds_pulse_o}));  // R4
    AST_WR_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |=> busy);                                                            // R8
    AST_WR_SHOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (sdo_oe_o && !sdo_o));                                            // R8
    AST_DAC_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd_o || mem_wr_o) && mem_addr_o[ADDR_W-1]) |-> (mem_addr_o[GEN_AW-1:DAC_SEL_W] == '0)); // R7
    AST_DAC_WDATA_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && mem_addr_o[ADDR_W-1]) |-> (mem_wdata_o[DATA_W-1:DAC_DW] == '0));  // R3
    AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.rd_act && !s_q.status) |-> !sdo_oe_o);                                   // R12
    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !s_q.in_frame) |=> !s_q.in_frame);                                    // R10
    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rd_act |-> !mem_wr_o);                                                     // R5
endmodule

// File: tb/nvm_serial_port_tb.sv
module nvm_serial_port_tb;
    localparam int BUSY = 40;
    localparam int HALF = 6;
    localparam logic [6:0] OP_RD = 7'b1010100;
    localparam logic [6:0] OP_WR = 7'b1010010;
    localparam logic [6:0] OP_EN = 7'b1010001;
    localparam logic [6:0] OP_DS = 7'b1010000;
    localparam logic [6:0] OP_PE = 7'b1010110;
    localparam logic [6:0] OP_PD = 7'b1010011;

    logic clk = 1'b0;
    logic rst_n, cs, sclk, sdi;
    logic sdo, sdo_oe, mem_rd, mem_wr;
    logic [8:0]  mem_addr;
    logic [15:0] mem_rdata, mem_wdata;
    logic p_en, p_ds, p_pe, p_pd;

    always #10 clk = ~clk;

    nvm_serial_port #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
        .mem_rdata_i(mem_rdata), .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata),
        .wren_pulse_o(p_en), .wrds_pulse_o(p_ds), .pden_pulse_o(p_pe), .pdds_pulse_o(p_pd)
    );

    logic [15:0] mem [0:259];
    int n_wr = 0, n_rd = 0, n_en = 0, n_ds = 0, n_pe = 0, n_pd = 0;
    logic [8:0]  last_wa = '0;
    logic [15:0] last_wd = '0;
    int checks = 0, fails = 0;
    bit done = 0;

    function automatic int idx(input logic [8:0] a);
        return a[8] ? 256 + int'(a[1:0]) : int'(a[7:0]);
    endfunction

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[idx(mem_addr)] <= mem_wdata;
            last_wa <= mem_addr;
            last_wd <= mem_wdata;
            n_wr <= n_wr + 1;
        end
        if (mem_rd) begin
            mem_rdata <= mem[idx(mem_addr)];
            n_rd <= n_rd + 1;
        end
        if (p_en) n_en <= n_en + 1;
        if (p_ds) n_ds <= n_ds + 1;
        if (p_pe) n_pe <= n_pe + 1;
        if (p_pd) n_pd <= n_pd + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        sclk = 1'b0; sdi = b; tick(HALF);
        sclk = 1'b1; tick(HALF);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    endtask

    function automatic logic [15:0] exp_word(input logic [8:0] a);
        if (a[8]) return {8'h00, mem[256 + int'(a[1:0])][7:0]};
        return mem[int'(a[7:0])];
    endfunction

    function automatic logic [8:0] exp_step(input logic [8:0] a);
        if (a[8]) return 9'h100 + 9'((int'(a[1:0]) + 1) % 4);
        return 9'((int'(a[7:0]) + 1) % 256);
    endfunction

    task automatic read_run(input logic [8:0] a0, input int words, input string req);
        logic [8:0]  a;
        logic [15:0] got;
        a = a0[8] ? (9'h100 + 9'(a0[1:0])) : a0;
        cs = 1'b1; tick(HALF);
        send_bits({16'h0, OP_RD, a0}, 16);
        chk("R12 hi-z before read data", 32'(sdo_oe), 0);
        for (int w = 0; w < words; w++) begin
            got = '0;
            for (int b = 15; b >= 0; b--) begin
                sclk = 1'b0; tick(HALF);
                if (w == 0 && b == 15) chk("R5 driven at first data edge", 32'(sdo_oe), 1);
                got[b] = sdo;
                sclk = 1'b1; tick(HALF);
            end
            chk(req, 32'(got), 32'(exp_word(a)));
            a = exp_step(a);
        end
        chk("R5 driven until cs drops", 32'(sdo_oe), 1);
        cs = 1'b0; tick(4);
        chk("R5 released at cs drop", 32'(sdo_oe), 0);
    endtask

    task automatic do_write(input logic [8:0] a, input logic [15:0] d);
        cs = 1'b1; tick(HALF);
        send_bits({OP_WR, a, d}, 32);
        tick(BUSY + 8);
        cs = 1'b0; tick(4);
    endtask

    task automatic do_ctl(input logic [6:0] op, input logic [8:0] a, input logic [15:0] d);
        cs = 1'b1; tick(HALF);
        send_bits({op, a, d}, 32);
        tick(3);
        cs = 1'b0; tick(4);
    endtask

    task automatic summary;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        int wr0, e0, d0, p0, q0;
        logic [8:0]  a;
        logic [15:0] d;
        cs = 0; sclk = 1; sdi = 0; rst_n = 0; mem_rdata = '0;
        for (int i = 0; i < 256; i++) mem[i] = 16'((i * 40503 + 4660) % 65536);
        for (int k = 0; k < 4; k++) mem[256 + k] = 16'hA500 | 16'((k * 60 + 17) % 256);
        tick(5); rst_n = 1; tick(6);

        // R1 reset state
        chk("R1 oe after reset", 32'(sdo_oe), 0);
        chk("R1 no strobes", 32'(n_wr + n_rd + n_en + n_ds + n_pe + n_pd), 0);

        // R6 general wrap, R7 converter region with masking and folding
        read_run(9'h0FC, 8, "R6 sequential general read");
        read_run(9'h042, 3, "R6 plain read");
        read_run(9'h102, 6, "R7 converter read wrap");
        read_run(9'h1F5, 3, "R7 folded converter read");

        // R4 control op-codes, address/data ignored
        e0 = n_en; d0 = n_ds; p0 = n_pe; q0 = n_pd; wr0 = n_wr;
        do_ctl(OP_EN, 9'h1AB, 16'hFFFF);
        chk("R4 wren count", 32'(n_en - e0), 1);
        do_ctl(OP_DS, 9'h055, 16'h1234);
        chk("R4 wrds count", 32'(n_ds - d0), 1);
        do_ctl(OP_PE, 9'h000, 16'h0000);
        chk("R4 pden count", 32'(n_pe - p0), 1);
        do_ctl(OP_PD, 9'h1FF, 16'hA5A5);
        chk("R4 pdds count", 32'(n_pd - q0), 1);
        chk("R4 other pulses unchanged", 32'((n_en - e0) + (n_ds - d0) + (n_pe - p0) + (n_pd - q0)), 4);
        do_ctl(7'b0101010, 9'h010, 16'h9999);
        chk("R4 unknown op no action", 32'((n_en - e0) + (n_ds - d0) + (n_pe - p0) + (n_pd - q0) + (n_wr - wr0)), 4);
        chk("R4 unknown op no write", 32'(n_wr - wr0), 0);
        chk("R12 idle after control", 32'(sdo_oe), 0);

        // R2/R3 write sweep over converter registers and a spread of words
        for (int k = 0; k < 4; k++) begin
            wr0 = n_wr;
            d = 16'h7700 | 16'((k * 37 + 5) % 256);
            do_write(9'h100 + 9'(k), d);
            chk("R3 converter write count", 32'(n_wr - wr0), 1);
            chk("R3 converter write addr", 32'(last_wa), 32'(9'h100 + 9'(k)));
            chk("R3 converter write data", 32'(last_wd), 32'({8'h00, d[7:0]}));
        end
        do_write(9'h1FE, 16'h1234);
        chk("R7 folded write addr", 32'(last_wa), 32'h102);
        chk("R7 folded write data", 32'(last_wd), 32'h0034);
        for (int k = 0; k < 64; k++) begin
            wr0 = n_wr;
            a = 9'(k * 4 + 3);
            d = 16'((int'(a) * 241) % 65536) ^ 16'hC0DE;
            do_write(a, d);
            chk("R2 write count", 32'(n_wr - wr0), 1);
            chk("R2 write addr", 32'(last_wa), 32'(a));
            chk("R3 write data", 32'(last_wd), 32'(d));
        end
        read_run(9'h100, 5, "R7 readback after writes");
        read_run(9'h0F3, 4, "R6 readback after writes");

        // R8/R9 status with cs held high, ended by cs drop after ready
        cs = 1'b1; tick(HALF);
        send_bits({OP_WR, 9'h011, 16'h5555}, 32);
        tick(HALF);
        chk("R12 mid-write hi-z check skipped phase oe", 32'(sdo_oe), 1);
        chk("R8 busy low", 32'(sdo), 0);
        tick(BUSY + 6);
        chk("R8 ready high", 32'(sdo), 1);
        chk("R8 still driven", 32'(sdo_oe), 1);
        cs = 1'b0; tick(4);
        chk("R9 released by cs drop", 32'(sdo_oe), 0);

        // R8/R10 cs dropped during busy, frame begun while busy is ignored
        cs = 1'b1; tick(HALF);
        send_bits({OP_WR, 9'h012, 16'h6666}, 32);
        tick(3);
        cs = 1'b0; tick(3);
        chk("R8 busy shown with cs low", 32'({sdo_oe, sdo}), 32'b10);
        e0 = n_en; wr0 = n_wr;
        cs = 1'b1; tick(2);
        send_bits({OP_EN, 9'h000, 16'h0000}, 32);
        tick(3);
        chk("R10 rejected frame no pulse", 32'(n_en - e0), 0);
        chk("R10 rejected frame no write", 32'(n_wr - wr0), 0);
        chk("R9 status kept through rejected frame", 32'({sdo_oe, sdo}), 32'b11);
        cs = 1'b0; tick(4);
        chk("R9 released by cs drop after ready", 32'(sdo_oe), 0);

        // R9 status ended by first bit of next accepted frame
        cs = 1'b1; tick(HALF);
        send_bits({OP_WR, 9'h013, 16'h7777}, 32);
        tick(3);
        cs = 1'b0; tick(BUSY + 8);
        chk("R8 ready with cs low", 32'({sdo_oe, sdo}), 32'b11);
        d0 = n_ds;
        cs = 1'b1; tick(HALF);
        chk("R9 kept after cs rise", 32'(sdo_oe), 1);
        sbit(OP_DS[6]);
        chk("R9 released by first bit", 32'(sdo_oe), 0);
        send_bits({OP_DS[5:0], 9'h000, 16'h0000}, 31);
        tick(3);
        cs = 1'b0; tick(4);
        chk("R9 following frame executes", 32'(n_ds - d0), 1);

        // R11 abort mid-frame
        wr0 = n_wr;
        cs = 1'b1; tick(HALF);
        send_bits({OP_WR, 9'h033, 16'h0000}, 20);
        cs = 1'b0; tick(4);
        chk("R11 aborted frame no write", 32'(n_wr - wr0), 0);
        do_write(9'h044, 16'hBEEF);
        chk("R11 next frame addr", 32'(last_wa), 32'h044);
        chk("R11 next frame data", 32'(last_wd), 32'hBEEF);
        wr0 = n_wr;
        cs = 1'b1; tick(HALF);
        send_bits({OP_WR, 9'h055, 16'h1111}, 31);
        cs = 1'b0; tick(4);
        chk("R11 abort before last bit", 32'(n_wr - wr0), 0);
        chk("R12 hi-z after abort", 32'(sdo_oe), 0);

        summary();
    end
endmodule